// File: doc/BRIEF.md
# Deferred-Commit Register Write Bridge

This block lets a host on a fast bus clock program the settings of a slow real-time timekeeping domain that runs from its own unrelated clock. The host sets a configuration-mode bit and writes staged copies of the prescaler reload, counter and alarm values. None of these writes reaches the slow domain while the mode bit is set. When the host clears the mode bit, a commit request crosses into the slow domain. Every staged register written during that session is then applied in one slow-clock cycle, and each applied register raises a one-cycle load strobe.

A read-only "write done" bit drops as the commit starts. It comes back only after an acknowledge has returned from the slow domain. The host must wait for it before starting another session. Any bus write made while the bit is low is dropped and sets a sticky error bit.

Top module: `cfgbridge_top`

## Requirements
- R1: After reset the control word reads mode=0, done=1, error=0. All slow-domain outputs and load strobes are 0.
- R2: The address map is 0 = control, 1 = prescaler stage, 2 = counter stage, 3 = alarm stage. Stage writes made while mode (control bit 0) is 1 read back at once but do not change the slow-domain outputs.
- R3: A control write that clears bit 0 while mode is 1 and done is 1 starts a commit. Done (control bit 1) reads 0 from the next bus cycle.
- R4: The slow domain applies a commit no earlier than the third slow-clock edge after the request. It pulses the load strobe of every applied register for exactly one slow cycle, all in the same cycle, with the new value present alongside the strobe.
- R5: Only stage registers written during the session are applied. The outputs of the others keep their value and their strobes stay low.
- R6: Done returns to 1 after the acknowledge comes back. A later session that writes nothing produces no load strobe.
- R7: Any write made while done is 0 is ignored: the stage values and the mode bit are unchanged. Such a write sets the sticky error bit (control bit 2). A control write with bit 2 set, made while done is 1, clears it.
- R8: A stage write made while mode is 0 and done is 1 is ignored and does not set the error bit.
- R9: The control word read back carries mode in bit 0, done in bit 1 and error in bit 2, with zeros above. Stage addresses read back the full written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| busClk | input | 1 | Host bus clock |
| busRstN | input | 1 | Active-low asynchronous reset, bus domain |
| busAddr | input | 2 | Register address |
| busWdata | input | DATA_W | Write data |
| busWe | input | 1 | Write strobe, one bus cycle per write |
| busRdata | output | DATA_W | Read data for busAddr |
| slowClk | input | 1 | Slow timekeeping clock |
| slowRstN | input | 1 | Active-low asynchronous reset, slow domain |
| pscOut | output | PSC_W | Applied prescaler reload |
| cntOut | output | CNT_W | Applied counter value |
| almOut | output | CNT_W | Applied alarm value |
| pscLoad | output | 1 | One-cycle prescaler load strobe |
| cntLoad | output | 1 | One-cycle counter load strobe |
| almLoad | output | 1 | One-cycle alarm load strobe |

## Verification
The bench targets a write that lands while a commit is still in flight. A design that let it through would corrupt a stage value the slow domain is sampling, or would start a second request over the first, and the error bit would stay clear. It runs a partial session that touches only the counter, so a design that ignores the dirty tracking shows spurious strobes or overwritten outputs. It also runs an empty session, which catches dirty bits that are never cleared, and it times each load against the request, so a crossing shorter than three slow edges is flagged. A scoreboard of expected commits catches loads spread over several cycles and loads that appear with nothing pending.

// File: rtl/cfgbridge_pkg.sv
package cfgbridge_pkg;
  localparam int NUM_STAGE = 3;
  localparam int IDX_PSC = 0;
  localparam int IDX_CNT = 1;
  localparam int IDX_ALM = 2;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PSC  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_ALM  = 2'd3;
  localparam int BIT_MODE = 0;
  localparam int BIT_DONE = 1;
  localparam int BIT_ERR  = 2;
  localparam int CTRL_BITS = 3;

  typedef struct packed {
    logic [NUM_STAGE-1:0] stageWr;
    logic                 commitReq;
  } ctrlStrobe_t;
endpackage

// File: rtl/cfgbridge_ctrl.sv
module cfgbridge_ctrl
  import cfgbridge_pkg::*;
(
  input  logic                  busClk,
  input  logic                  busRstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [CTRL_BITS-1:0]  ctrlBits,
  input  logic                  busWe,
  input  logic                  ackToggle,
  output ctrlStrobe_t           stb,
  output logic                  reqToggle,
  output logic [NUM_STAGE-1:0]  dirty,
  output logic                  cfgMode,
  output logic                  done,
  output logic                  errFlag
);
  logic ackS1, ackS2, ackSeen;
  logic writeOk, ackArrive, ctrlHit;

  // two-flop synchronizer for the returning acknowledge
  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      ackS1 <= 1'b0;
      ackS2 <= 1'b0;
    end else begin
      ackS1 <= ackToggle;
      ackS2 <= ackS1;
    end
  end

  assign done      = (reqToggle == ackSeen);
  assign ackArrive = (ackS2 != ackSeen);
  assign writeOk   = busWe && done;
  assign ctrlHit   = writeOk && (busAddr == ADDR_CTRL);

  always_comb begin
    stb = '0;
    if (writeOk && cfgMode) begin
      case (busAddr)
        ADDR_PSC: stb.stageWr[IDX_PSC] = 1'b1;
        ADDR_CNT: stb.stageWr[IDX_CNT] = 1'b1;
        ADDR_ALM: stb.stageWr[IDX_ALM] = 1'b1;
        default:  ;
      endcase
    end
    stb.commitReq = ctrlHit && cfgMode && !ctrlBits[BIT_MODE];
  end

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      cfgMode   <= 1'b0;
      reqToggle <= 1'b0;
      ackSeen   <= 1'b0;
      errFlag   <= 1'b0;
      dirty     <= '0;
    end else begin
      if (ctrlHit) cfgMode <= ctrlBits[BIT_MODE];
      if (stb.commitReq) reqToggle <= ~reqToggle;
      if (ackArrive) begin
        ackSeen <= ackS2;
        dirty   <= '0;
      end else begin
        dirty <= dirty | stb.stageWr;
      end
      if (busWe && !done) errFlag <= 1'b1;
      else if (ctrlHit && ctrlBits[BIT_ERR]) errFlag <= 1'b0;
    end
  end

  assert_commit_drops_done_R3: assert property (@(posedge busClk) disable iff (!busRstN)
    stb.commitReq |=> !done);
  assert_busy_write_flags_R7: assert property (@(posedge busClk) disable iff (!busRstN)
    (busWe && !done) |=> (errFlag && $stable(cfgMode)));
  assert_dirty_clear_on_ack_R6: assert property (@(posedge busClk) disable iff (!busRstN)
    $rose(done) |-> (dirty == '0));
endmodule

// File: rtl/cfgbridge_dp.sv
module cfgbridge_dp
  import cfgbridge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PSC_W  = 20,
  parameter int CNT_W  = 32
) (
  input  logic                  busClk,
  input  logic                  busRstN,
  input  ctrlStrobe_t           stb,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  input  logic                  cfgMode,
  input  logic                  done,
  input  logic                  errFlag,
  output logic [DATA_W-1:0]     busRdata,
  output logic [PSC_W-1:0]      stagePsc,
  output logic [CNT_W-1:0]      stageCnt,
  output logic [CNT_W-1:0]      stageAlm
);
  logic [NUM_STAGE-1:0][DATA_W-1:0] stageReg;

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      stageReg <= '0;
    end else begin
      for (int i = 0; i < NUM_STAGE; i++) begin
        if (stb.stageWr[i]) stageReg[i] <= busWdata;
      end
    end
  end

  assign stagePsc = stageReg[IDX_PSC][PSC_W-1:0];
  assign stageCnt = stageReg[IDX_CNT][CNT_W-1:0];
  assign stageAlm = stageReg[IDX_ALM][CNT_W-1:0];

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_CTRL: begin
        busRdata[BIT_MODE] = cfgMode;
        busRdata[BIT_DONE] = done;
        busRdata[BIT_ERR]  = errFlag;
      end
      ADDR_PSC: busRdata = stageReg[IDX_PSC];
      ADDR_CNT: busRdata = stageReg[IDX_CNT];
      default:  busRdata = stageReg[IDX_ALM];
    endcase
  end

  assert_stage_frozen_busy_R7: assert property (@(posedge busClk) disable iff (!busRstN)
    !done |=> $stable(stageReg));
  assert_stage_frozen_idle_R8: assert property (@(posedge busClk) disable iff (!busRstN)
    !cfgMode |=> $stable(stageReg));
endmodule

// File: rtl/cfgbridge_apply.sv
module cfgbridge_apply
  import cfgbridge_pkg::*;
#(
  parameter int PSC_W = 20,
  parameter int CNT_W = 32
) (
  input  logic                  slowClk,
  input  logic                  slowRstN,
  input  logic                  reqToggle,
  input  logic [NUM_STAGE-1:0]  dirty,
  input  logic [PSC_W-1:0]      stagePsc,
  input  logic [CNT_W-1:0]      stageCnt,
  input  logic [CNT_W-1:0]      stageAlm,
  output logic [PSC_W-1:0]      pscOut,
  output logic [CNT_W-1:0]      cntOut,
  output logic [CNT_W-1:0]      almOut,
  output logic [NUM_STAGE-1:0]  loadStb,
  output logic                  ackToggle
);
  logic reqS1, reqS2, reqSeen, commitHit;

  assign commitHit = (reqS2 != reqSeen);
  assign ackToggle = reqSeen;

  always_ff @(posedge slowClk or negedge slowRstN) begin
    if (!slowRstN) begin
      reqS1   <= 1'b0;
      reqS2   <= 1'b0;
      reqSeen <= 1'b0;
      loadStb <= '0;
      pscOut  <= '0;
      cntOut  <= '0;
      almOut  <= '0;
    end else begin
      reqS1   <= reqToggle;
      reqS2   <= reqS1;
      reqSeen <= reqS2;
      loadStb <= commitHit ? dirty : '0;
      if (commitHit && dirty[IDX_PSC]) pscOut <= stagePsc;
      if (commitHit && dirty[IDX_CNT]) cntOut <= stageCnt;
      if (commitHit && dirty[IDX_ALM]) almOut <= stageAlm;
    end
  end

  assert_load_single_cycle_R4: assert property (@(posedge slowClk) disable iff (!slowRstN)
    (|loadStb) |=> (loadStb == '0));
  assert_load_with_ack_R4: assert property (@(posedge slowClk) disable iff (!slowRstN)
    (|loadStb) |-> !$stable(ackToggle));
  assert_psc_hold_R5: assert property (@(posedge slowClk) disable iff (!slowRstN)
    !loadStb[IDX_PSC] |-> $stable(pscOut));
  assert_cnt_hold_R5: assert property (@(posedge slowClk) disable iff (!slowRstN)
    !loadStb[IDX_CNT] |-> $stable(cntOut));
  assert_alm_hold_R5: assert property (@(posedge slowClk) disable iff (!slowRstN)
    !loadStb[IDX_ALM] |-> $stable(almOut));
endmodule

// File: rtl/cfgbridge_top.sv
module cfgbridge_top
  import cfgbridge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PSC_W  = 20,
  parameter int CNT_W  = 32
) (
  input  logic               busClk,
  input  logic               busRstN,
  input  logic [1:0]         busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic               busWe,
  output logic [DATA_W-1:0]  busRdata,
  input  logic               slowClk,
  input  logic               slowRstN,
  output logic [PSC_W-1:0]   pscOut,
  output logic [CNT_W-1:0]   cntOut,
  output logic [CNT_W-1:0]   almOut,
  output logic               pscLoad,
  output logic               cntLoad,
  output logic               almLoad
);
  ctrlStrobe_t           stb;
  logic                  reqToggle, ackToggle, cfgMode, done, errFlag;
  logic [NUM_STAGE-1:0]  dirty, loadStb;
  logic [PSC_W-1:0]      stagePsc;
  logic [CNT_W-1:0]      stageCnt, stageAlm;

  cfgbridge_ctrl uCtrl (
    .busClk(busClk), .busRstN(busRstN), .busAddr(busAddr),
    .ctrlBits(busWdata[CTRL_BITS-1:0]), .busWe(busWe), .ackToggle(ackToggle),
    .stb(stb), .reqToggle(reqToggle), .dirty(dirty), .cfgMode(cfgMode),
    .done(done), .errFlag(errFlag)
  );

  cfgbridge_dp #(.DATA_W(DATA_W), .PSC_W(PSC_W), .CNT_W(CNT_W)) uDp (
    .busClk(busClk), .busRstN(busRstN), .stb(stb), .busAddr(busAddr),
    .busWdata(busWdata), .cfgMode(cfgMode), .done(done), .errFlag(errFlag),
    .busRdata(busRdata), .stagePsc(stagePsc), .stageCnt(stageCnt), .stageAlm(stageAlm)
  );

  cfgbridge_apply #(.PSC_W(PSC_W), .CNT_W(CNT_W)) uApply (
    .slowClk(slowClk), .slowRstN(slowRstN), .reqToggle(reqToggle), .dirty(dirty),
    .stagePsc(stagePsc), .stageCnt(stageCnt), .stageAlm(stageAlm),
    .pscOut(pscOut), .cntOut(cntOut), .almOut(almOut), .loadStb(loadStb),
    .ackToggle(ackToggle)
  );

  assign pscLoad = loadStb[IDX_PSC];
  assign cntLoad = loadStb[IDX_CNT];
  assign almLoad = loadStb[IDX_ALM];
endmodule

// File: tb/cfgbridge_top_test.sv
module cfgbridge_top_test;
  localparam int DATA_W = 32;
  localparam int PSC_W = 20;
  localparam int CNT_W = 32;
  localparam real BUS_PER = 8.0;
  localparam real SLOW_PER = 37.0;

  typedef struct {
    logic [2:0]        mask;
    logic [PSC_W-1:0]  psc;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  alm;
    realtime           tReq;
  } commit_t;

  logic busClk = 0, slowClk = 0, busRstN = 0, slowRstN = 0;
  logic [1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic busWe = 0;
  logic [DATA_W-1:0] busRdata;
  logic [PSC_W-1:0] pscOut;
  logic [CNT_W-1:0] cntOut, almOut;
  logic pscLoad, cntLoad, almLoad;

  int checks = 0, fails = 0;
  commit_t expQ[$];
  logic [PSC_W-1:0] mPsc = '0;
  logic [CNT_W-1:0] mCnt = '0, mAlm = '0;
  bit finished = 0;

  always #(BUS_PER/2) busClk = ~busClk;
  always #(SLOW_PER/2) slowClk = ~slowClk;

  cfgbridge_top #(.DATA_W(DATA_W), .PSC_W(PSC_W), .CNT_W(CNT_W)) uut (
    .busClk(busClk), .busRstN(busRstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata), .slowClk(slowClk), .slowRstN(slowRstN),
    .pscOut(pscOut), .cntOut(cntOut), .almOut(almOut),
    .pscLoad(pscLoad), .cntLoad(cntLoad), .almLoad(almLoad)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge busClk);
    busAddr = a; busWdata = d; busWe = 1;
    @(negedge busClk);
    busWe = 0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [DATA_W-1:0] d);
    @(negedge busClk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic waitDone(input string req);
    logic [DATA_W-1:0] d;
    int n = 0;
    do begin
      busRead(2'd0, d);
      n++;
    end while (!d[1] && n < 500);
    check(d[1] == 1'b1, req, d[1], 1);
  endtask

  // clears mode and records the expected commit for the monitor
  task automatic commit(input logic [2:0] mask, input logic [PSC_W-1:0] p,
                        input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] al);
    commit_t it;
    it.mask = mask; it.psc = p; it.cnt = c; it.alm = al; it.tReq = $realtime;
    if (mask != 0) expQ.push_back(it);
    busWrite(2'd0, 32'd0);
  endtask

  // monitor: compares every load against the scoreboard
  always @(negedge slowClk) begin
    if (slowRstN && (pscLoad || cntLoad || almLoad)) begin
      if (expQ.size() == 0) begin
        check(0, "R6 unexpected load", {pscLoad, cntLoad, almLoad}, 0);
      end else begin
        commit_t it;
        it = expQ.pop_front();
        check({almLoad, cntLoad, pscLoad} == it.mask, "R5 load mask",
              {almLoad, cntLoad, pscLoad}, it.mask);
        if (it.mask[0]) mPsc = it.psc;
        if (it.mask[1]) mCnt = it.cnt;
        if (it.mask[2]) mAlm = it.alm;
        check(pscOut == mPsc, "R4 psc value", pscOut, mPsc);
        check(cntOut == mCnt, "R4 cnt value", cntOut, mCnt);
        check(almOut == mAlm, "R4 alm value", almOut, mAlm);
        check(($realtime - it.tReq) > 2.0 * SLOW_PER, "R4 latency",
              longint'($realtime - it.tReq), longint'(2.0 * SLOW_PER));
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] d;
    #50;
    @(negedge busClk); busRstN = 1; slowRstN = 1;

    // R1 reset state
    busRead(2'd0, d);
    check(d == 32'h2, "R1 ctrl reset", d, 2);
    check(pscOut == 0 && cntOut == 0 && almOut == 0, "R1 outputs reset", cntOut, 0);
    check({pscLoad, cntLoad, almLoad} == 0, "R1 strobes reset", {pscLoad, cntLoad, almLoad}, 0);

    // R2 full session
    busWrite(2'd0, 32'h1);
    busWrite(2'd1, 32'h5);
    busWrite(2'd2, 32'h100);
    busWrite(2'd3, 32'h200);
    busRead(2'd1, d);
    check(d == 32'h5, "R2 psc readback", d, 5);
    busRead(2'd0, d);
    check(d == 32'h3, "R9 ctrl in mode", d, 3);
    repeat (20) @(negedge busClk);
    check(cntOut == 0 && pscOut == 0, "R2 not applied in mode", cntOut, 0);
    commit(3'b111, 20'h5, 32'h100, 32'h200);
    busRead(2'd0, d);
    check(d[1] == 1'b0, "R3 done drops", d[1], 0);
    waitDone("R6 done returns");
    busRead(2'd2, d);
    check(d == 32'h100, "R9 cnt readback", d, 32'h100);
    busRead(2'd3, d);
    check(d == 32'h200, "R9 alm readback", d, 32'h200);

    // R5 partial session
    busWrite(2'd0, 32'h1);
    busWrite(2'd2, 32'h77);
    commit(3'b010, '0, 32'h77, '0);
    waitDone("R6 done after partial");
    check(pscOut == 20'h5 && almOut == 32'h200, "R5 clean regs kept", almOut, 32'h200);
    check(cntOut == 32'h77, "R5 dirty reg applied", cntOut, 32'h77);

    // R6 empty session
    busWrite(2'd0, 32'h1);
    commit(3'b000, '0, '0, '0);
    waitDone("R6 done after empty");
    repeat (40) @(negedge busClk);
    check(expQ.size() == 0, "R6 queue drained", expQ.size(), 0);

    // R7 writes while busy
    busWrite(2'd0, 32'h1);
    busWrite(2'd3, 32'h55);
    commit(3'b100, '0, '0, 32'h55);
    busWrite(2'd1, 32'h99);
    busWrite(2'd0, 32'h1);
    busRead(2'd0, d);
    check(d == 32'h4, "R7 error set, mode unchanged", d, 4);
    waitDone("R7 done");
    busRead(2'd1, d);
    check(d == 32'h5, "R7 stage unchanged", d, 5);
    check(pscOut == 20'h5, "R7 psc output unchanged", pscOut, 5);
    busWrite(2'd0, 32'h4);
    busRead(2'd0, d);
    check(d == 32'h2, "R7 error cleared", d, 2);

    // R8 stage write outside mode
    busWrite(2'd1, 32'h123);
    busRead(2'd1, d);
    check(d == 32'h5, "R8 ignored outside mode", d, 5);
    busRead(2'd0, d);
    check(d == 32'h2, "R8 no error", d, 2);
    repeat (40) @(negedge busClk);
    check(pscOut == 20'h5 && expQ.size() == 0, "R8 no load", pscOut, 5);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule